// File: doc/BRIEF.md
# Multicycle Accumulator CPU

This block is a small, non-pipelined processor with an 8-bit data path and an 8-bit address space of 256 bytes. It holds two data registers and a single zero flag. All instruction fetches, operand fetches, pointer reads and stores go through one byte-wide memory port. Every instruction runs to completion before the next opcode fetch starts.

The memory port uses valid/ready. The CPU raises `mem_req_valid` with an address, a write flag and write data. It holds all of them stable until `mem_req_ready` is seen high at a rising clock edge, and that edge is the accepted transfer. A write is complete at that handshake and gets no response. An accepted read is answered by the memory with exactly one `mem_rsp_valid` pulse carrying `mem_rsp_data`. The pulse may come one or more cycles later. The CPU keeps at most one read outstanding and makes no new request until the response arrives, so it needs no response back-pressure.

An instruction is one opcode byte, `{op[3:0], rd, rs, mode[1:0]}`, optionally followed by one operand byte. The mode codes are 0 register, 1 immediate, 2 direct and 3 indirect. The op codes are:

| Code | Op |
|---|---|
| 0 | no-op |
| 1 | load/move |
| 2 | store |
| 3 | add |
| 4 | subtract |
| 5 | compare |
| 6 | OR |
| 7 | decrement |
| 8 | invert |
| 9 | shift-left |
| A | jump |
| B | jump-if-zero |
| C | jump-if-not-zero |
| F | halt |

Codes D and E act as no-ops.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high `rst` clears both data registers, the zero flag and the program counter. The first request after reset is a read of address 0x00, and `halted` is low.
- R2: Opcode bits [7:4] select the operation, bit 3 the destination register, bit 2 the source register and bits [1:0] the mode. Jumps always take one operand byte. Load, store, add, subtract, compare and OR take one operand byte unless the mode is register (0). All other ops are a single byte.
- R3: The operand value is the register `rs` in mode 0, the operand byte in mode 1, the memory byte at the operand address in mode 2, and the memory byte at the address read from the operand address in mode 3. Load in mode 0 copies `rs` into `rd`.
- R4: Add, subtract and OR write `rd op value` modulo 256 to `rd`, and set the zero flag exactly when that 8-bit result is 0x00.
- R5: Compare sets the zero flag when `rd - value` is 0x00 and clears it otherwise, and leaves `rd` unchanged.
- R6: Decrement writes `rd - 1` modulo 256. Invert writes the bitwise complement of `rd`. Shift-left writes `rd` moved up one bit with 0 entering bit 0 and bit 7 dropped. Each of these updates the zero flag from its result.
- R7: Store writes `rd` to the effective address. That address is the operand byte in mode 2, or the byte read from the operand address in mode 3.
- R8: Jump loads the operand byte into the program counter. Jump-if-zero does so only when the zero flag is 1, and jump-if-not-zero only when it is 0. Otherwise execution falls through.
- R9: The program counter wraps from 0xFF to 0x00, including between an opcode at 0xFF and its operand byte.
- R10: The halt opcode raises `halted`, which then stays high until reset, and no further memory request is made.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, write flag and data stay unchanged. No request is made while a read awaits its response.
- R12: Load and move do not change the zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 8 | Request byte address |
| mem_req_wdata | output | 8 | Write data for a store |
| mem_rsp_valid | input | 1 | Read response present (one pulse per accepted read) |
| mem_rsp_data | input | 8 | Read response byte |
| halted | output | 1 | Halt opcode executed |

## Verification
Two functions can land on the same cycle. The first is the program counter increment that wraps 0xFF to 0x00. The second is the issue of the operand request that must use the wrapped address. The bench provokes this by jumping to an immediate add placed at 0xFF, so its operand is the byte at 0x00, which is also the program's first opcode. The run uses heavy ready back-pressure and slow responses, so the wrapped request is held over several cycles. The check is that the sum, stored after a conditional second pass, equals the first register value plus the byte at 0x00. A monitor also counts any change to a stalled request.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_LOAD  = 4'h1,
    OP_STORE = 4'h2,
    OP_ADD   = 4'h3,
    OP_SUB   = 4'h4,
    OP_CMP   = 4'h5,
    OP_OR    = 4'h6,
    OP_DEC   = 4'h7,
    OP_NOT   = 4'h8,
    OP_SHL   = 4'h9,
    OP_JMP   = 4'hA,
    OP_JZ    = 4'hB,
    OP_JNZ   = 4'hC,
    OP_RSV0  = 4'hD,
    OP_RSV1  = 4'hE,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_IMM = 2'd1,
    AM_DIR = 2'd2,
    AM_IND = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_OR,
    ALU_DEC,
    ALU_NOT,
    ALU_SHL
  } alu_op_e;

  typedef enum logic [3:0] {
    S_FETCH,   // issue opcode read
    S_FWAIT,   // wait opcode byte
    S_DECODE,
    S_OPND,    // issue operand byte read
    S_OWAIT,
    S_PTR,     // issue pointer read (indirect)
    S_PWAIT,
    S_DATA,    // issue data read at effective address
    S_DWAIT,
    S_EXEC,
    S_WB,      // issue store write
    S_HALT
  } state_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   y,
  output logic            zero
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_OR:  y = a | b;
      ALU_DEC: y = a - DW'(1);
      ALU_NOT: y = ~a;
      ALU_SHL: y = {a[DW-2:0], 1'b0};
      default: y = b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs #(
  parameter int DW   = 8,
  parameter int NREG = 2,
  localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] asel,
  input  logic [SW-1:0] bsel,
  output logic [DW-1:0] adata,
  output logic [DW-1:0] bdata
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (we && wsel == SW'(i))
        regs[i] <= wdata;
    end
  end

  assign adata = regs[asel];
  assign bdata = regs[bsel];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          halted,
  output logic          rd_sel,
  output logic          rs_sel,
  input  logic [DW-1:0] rd_val,
  input  logic [DW-1:0] rs_val,
  output alu_op_e       alu_op,
  output logic [DW-1:0] alu_b,
  input  logic [DW-1:0] alu_y,
  input  logic          alu_zero,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata
);

  state_e        state;
  logic [DW-1:0] pc, ir, opnd, ea;
  logic          zflag;

  opcode_e op;
  amode_e  mode;
  logic    is_jump, is_bin, is_store, has_opnd, sets_z, writes_rd, take_jump;

  assign op     = opcode_e'(ir[7:4]);
  assign mode   = amode_e'(ir[1:0]);
  assign rd_sel = ir[3];
  assign rs_sel = ir[2];

  assign is_jump  = (op == OP_JMP) || (op == OP_JZ) || (op == OP_JNZ);
  assign is_store = (op == OP_STORE);
  assign is_bin   = (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) ||
                    (op == OP_CMP)  || (op == OP_OR);
  assign has_opnd = is_jump || ((is_bin || is_store) && mode != AM_REG);
  assign sets_z   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) ||
                    (op == OP_OR)  || (op == OP_DEC) || (op == OP_NOT) ||
                    (op == OP_SHL);
  assign writes_rd = sets_z && (op != OP_CMP) || (op == OP_LOAD);
  assign take_jump = (op == OP_JMP) || (op == OP_JZ && zflag) ||
                     (op == OP_JNZ && !zflag);

  always_comb begin
    case (op)
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      OP_CMP:  alu_op = ALU_SUB;
      OP_OR:   alu_op = ALU_OR;
      OP_DEC:  alu_op = ALU_DEC;
      OP_NOT:  alu_op = ALU_NOT;
      OP_SHL:  alu_op = ALU_SHL;
      default: alu_op = ALU_PASS;
    endcase
  end

  assign alu_b     = (mode == AM_REG) ? rs_val : opnd;
  assign reg_we    = (state == S_EXEC) && writes_rd;
  assign reg_wdata = alu_y;

  // Memory request side
  always_comb begin
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = pc;
    case (state)
      S_FETCH, S_OPND: begin req_valid = 1'b1; req_addr = pc; end
      S_PTR:           begin req_valid = 1'b1; req_addr = opnd; end
      S_DATA:          begin req_valid = 1'b1; req_addr = ea; end
      S_WB:            begin req_valid = 1'b1; req_addr = ea; req_write = 1'b1; end
      default: ;
    endcase
  end
  assign req_wdata = rd_val;
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      opnd  <= '0;
      ea    <= '0;
      zflag <= 1'b0;
    end else begin
      case (state)
        S_FETCH: if (req_ready) state <= S_FWAIT;
        S_FWAIT: if (rsp_valid) begin
          ir    <= rsp_data;
          pc    <= pc + DW'(1);
          state <= S_DECODE;
        end
        S_DECODE: begin
          if (op == OP_HALT)  state <= S_HALT;
          else if (has_opnd)  state <= S_OPND;
          else                state <= S_EXEC;
        end
        S_OPND: if (req_ready) state <= S_OWAIT;
        S_OWAIT: if (rsp_valid) begin
          opnd <= rsp_data;
          pc   <= pc + DW'(1);
          if (is_jump || mode == AM_IMM) begin
            state <= S_EXEC;
          end else if (mode == AM_DIR) begin
            ea    <= rsp_data;
            state <= is_store ? S_WB : S_DATA;
          end else begin
            state <= S_PTR;
          end
        end
        S_PTR: if (req_ready) state <= S_PWAIT;
        S_PWAIT: if (rsp_valid) begin
          ea    <= rsp_data;
          state <= is_store ? S_WB : S_DATA;
        end
        S_DATA: if (req_ready) state <= S_DWAIT;
        S_DWAIT: if (rsp_valid) begin
          opnd  <= rsp_data;
          state <= S_EXEC;
        end
        S_EXEC: begin
          if (is_jump && take_jump) pc <= opnd;
          if (sets_z) zflag <= alu_zero;
          state <= S_FETCH;
        end
        S_WB:   if (req_ready) state <= S_FETCH;
        S_HALT: state <= S_HALT;
        default: state <= S_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 2
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          halted
);

  logic          rd_sel, rs_sel, reg_we, alu_zero;
  logic [DW-1:0] rd_val, rs_val, alu_b, alu_y, reg_wdata;
  alu_op_e       alu_op;

  acc_cpu_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_write (mem_req_write),
    .req_addr  (mem_req_addr),
    .req_wdata (mem_req_wdata),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .halted    (halted),
    .rd_sel    (rd_sel),
    .rs_sel    (rs_sel),
    .rd_val    (rd_val),
    .rs_val    (rs_val),
    .alu_op    (alu_op),
    .alu_b     (alu_b),
    .alu_y     (alu_y),
    .alu_zero  (alu_zero),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata)
  );

  acc_cpu_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .wsel  (rd_sel),
    .wdata (reg_wdata),
    .asel  (rd_sel),
    .bsel  (rs_sel),
    .adata (rd_val),
    .bdata (rs_val)
  );

  acc_cpu_alu #(.DW(DW)) u_alu (
    .op   (alu_op),
    .a    (rd_val),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [DW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          mem_rsp_valid,
  input logic          halted
);

  logic rd_pending, seen_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pending <= 1'b0;
      seen_req   <= 1'b0;
    end else begin
      if (mem_req_valid) seen_req <= 1'b1;
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pending <= 1'b1;
      else if (mem_rsp_valid)                               rd_pending <= 1'b0;
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R11
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !rd_pending);

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_req_valid);

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !seen_req |-> mem_req_addr == '0 && !mem_req_write);

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .halted        (halted)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mem_req_valid, mem_req_write, mem_req_ready, mem_rsp_valid, halted;
  logic [7:0] mem_req_addr, mem_req_wdata, mem_rsp_data;

  logic [7:0] mem [256];
  logic [7:0] rd_lat;
  logic [1:0] rd_cnt;
  logic [1:0] cyc = '0;
  logic       stall_en = 1'b0;
  int         n_chk = 0, n_fail = 0, hold_err = 0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_addr;
  logic       prev_wr;
  bit         done = 1'b0;

  localparam logic [1:0] MREG = 2'd0, MIMM = 2'd1, MDIR = 2'd2, MIND = 2'd3;

  always #4 clk = ~clk;  // 125 MHz

  acc_cpu u_dut (
    .clk(clk), .rst(rst),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .halted(halted)
  );

  // Memory model: valid/ready request, one response pulse per read
  assign mem_req_ready = !stall_en || (cyc == 2'b11);
  assign mem_rsp_valid = (rd_cnt == 2'd1);
  assign mem_rsp_data  = rd_lat;

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (rst) begin
      rd_cnt <= '0;
    end else begin
      if (rd_cnt != 0) rd_cnt <= rd_cnt - 2'd1;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) mem[mem_req_addr] <= mem_req_wdata;
        else begin
          rd_lat <= mem[mem_req_addr];
          rd_cnt <= stall_en ? 2'd2 : 2'd1;
        end
      end
    end
  end

  // Stalled-request monitor (R11)
  always @(negedge clk) begin
    if (!rst && prev_stall &&
        (!mem_req_valid || mem_req_addr != prev_addr || mem_req_write != prev_wr))
      hold_err++;
    prev_stall = !rst && mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    prev_wr    = mem_req_write;
  end

  function automatic logic [7:0] enc(input logic [3:0] op, input logic rd,
                                     input logic rs, input logic [1:0] md);
    return {op, rd, rs, md};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hF0;  // halt everywhere
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    check({req, " halt reached"}, {7'd0, halted}, 8'h01);
  endtask

  task automatic final_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // R1: reset clears registers, flag and PC
  task automatic t_reset();
    stall_en = 1'b0;
    clear_mem();
    put(8'h00, enc(4'h1, 1'b0, 1'b0, MIMM)); put(8'h01, 8'h99);
    put(8'h02, enc(4'h1, 1'b1, 1'b0, MIMM)); put(8'h03, 8'h77);
    put(8'h04, enc(4'h4, 1'b1, 1'b0, MIMM)); put(8'h05, 8'h77);
    do_reset();
    wait_halt("R1 setup");
    clear_mem();
    put(8'h00, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h01, 8'hD0);
    put(8'h02, enc(4'h2, 1'b1, 1'b0, MDIR)); put(8'h03, 8'hD1);
    put(8'h04, 8'hB0);                       put(8'h05, 8'h10);
    put(8'h06, enc(4'h1, 1'b0, 1'b0, MIMM)); put(8'h07, 8'h3C);
    put(8'h08, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h09, 8'hD2);
    do_reset();
    check("R1 first req valid", {7'd0, mem_req_valid}, 8'h01);
    check("R1 first req addr", mem_req_addr, 8'h00);
    check("R1 first req read", {7'd0, mem_req_write}, 8'h00);
    check("R1 halted low", {7'd0, halted}, 8'h00);
    wait_halt("R1");
    check("R1 r0 cleared", mem[8'hD0], 8'h00);
    check("R1 r1 cleared", mem[8'hD1], 8'h00);
    check("R1 zero flag cleared", mem[8'hD2], 8'h3C);
  endtask

  // R4, R2: add/sub wrap and zero
  task automatic t_arith();
    stall_en = 1'b0;
    clear_mem();
    put(8'h00, enc(4'h1, 1'b0, 1'b0, MIMM)); put(8'h01, 8'hF0);
    put(8'h02, enc(4'h3, 1'b0, 1'b0, MIMM)); put(8'h03, 8'h20);
    put(8'h04, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h05, 8'h80);
    put(8'h06, enc(4'h4, 1'b0, 1'b0, MIMM)); put(8'h07, 8'h10);
    put(8'h08, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h09, 8'h81);
    put(8'h0A, 8'hB0);                       put(8'h0B, 8'h20);
    put(8'h20, enc(4'h1, 1'b1, 1'b0, MIMM)); put(8'h21, 8'h01);
    put(8'h22, enc(4'h2, 1'b1, 1'b0, MDIR)); put(8'h23, 8'h82);
    do_reset();
    wait_halt("R4");
    check("R4 add wraps", mem[8'h80], 8'h10);
    check("R4 sub result", mem[8'h81], 8'h00);
    check("R4 sub sets zero", mem[8'h82], 8'h01);
  endtask

  // R3, R7: addressing modes (also run under back-pressure for R11)
  task automatic t_modes(input bit stall, input string tag);
    stall_en = stall;
    clear_mem();
    put(8'h90, 8'h33); put(8'h91, 8'h90); put(8'h92, 8'hA1);
    put(8'h00, enc(4'h1, 1'b0, 1'b0, MDIR)); put(8'h01, 8'h90);
    put(8'h02, enc(4'h1, 1'b1, 1'b0, MIND)); put(8'h03, 8'h91);
    put(8'h04, enc(4'h3, 1'b0, 1'b1, MREG));
    put(8'h05, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h06, 8'hA0);
    put(8'h07, enc(4'h2, 1'b1, 1'b0, MIND)); put(8'h08, 8'h92);
    put(8'h09, enc(4'h1, 1'b1, 1'b0, MREG));
    put(8'h0A, enc(4'h2, 1'b1, 1'b0, MDIR)); put(8'h0B, 8'hA2);
    do_reset();
    wait_halt({tag, " R3"});
    check({tag, " R3 direct+register add"}, mem[8'hA0], 8'h66);
    check({tag, " R7 R3 indirect load/store"}, mem[8'hA1], 8'h33);
    check({tag, " R3 move"}, mem[8'hA2], 8'h66);
    stall_en = 1'b0;
  endtask

  // R6: unary ops, plus OR (R4)
  task automatic t_unary();
    stall_en = 1'b0;
    clear_mem();
    put(8'h00, enc(4'h1, 1'b0, 1'b0, MIMM)); put(8'h01, 8'h81);
    put(8'h02, enc(4'h9, 1'b0, 1'b0, MREG));
    put(8'h03, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h04, 8'hA0);
    put(8'h05, enc(4'h8, 1'b0, 1'b0, MREG));
    put(8'h06, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h07, 8'hA1);
    put(8'h08, enc(4'h7, 1'b0, 1'b0, MREG));
    put(8'h09, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h0A, 8'hA2);
    put(8'h0B, enc(4'h6, 1'b0, 1'b0, MIMM)); put(8'h0C, 8'h03);
    put(8'h0D, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h0E, 8'hA3);
    put(8'h0F, enc(4'h1, 1'b1, 1'b0, MIMM)); put(8'h10, 8'h01);
    put(8'h11, enc(4'h7, 1'b1, 1'b0, MREG));
    put(8'h12, 8'hB0);                       put(8'h13, 8'h20);
    put(8'h20, enc(4'h2, 1'b1, 1'b0, MDIR)); put(8'h21, 8'hA4);
    do_reset();
    wait_halt("R6");
    check("R6 shift left drops bit7", mem[8'hA0], 8'h02);
    check("R6 invert", mem[8'hA1], 8'hFD);
    check("R6 decrement", mem[8'hA2], 8'hFC);
    check("R4 or", mem[8'hA3], 8'hFF);
    check("R6 decrement to zero sets flag", mem[8'hA4], 8'h00);
  endtask

  // R5, R8, R12: compare and jumps
  task automatic t_branch();
    stall_en = 1'b0;
    clear_mem();
    put(8'h00, enc(4'h1, 1'b0, 1'b0, MIMM)); put(8'h01, 8'h05);
    put(8'h02, enc(4'h5, 1'b0, 1'b0, MIMM)); put(8'h03, 8'h05);
    put(8'h04, 8'hB0);                       put(8'h05, 8'h20);
    put(8'h20, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h21, 8'hB0);
    put(8'h22, enc(4'h5, 1'b0, 1'b0, MIMM)); put(8'h23, 8'h06);
    put(8'h24, 8'hC0);                       put(8'h25, 8'h30);
    put(8'h30, enc(4'h1, 1'b1, 1'b0, MIMM)); put(8'h31, 8'h77);
    put(8'h32, enc(4'h2, 1'b1, 1'b0, MDIR)); put(8'h33, 8'hB1);
    put(8'h34, 8'hA0);                       put(8'h35, 8'h40);
    put(8'h40, enc(4'h4, 1'b0, 1'b0, MIMM)); put(8'h41, 8'h05);
    put(8'h42, enc(4'h1, 1'b1, 1'b0, MIMM)); put(8'h43, 8'h09);
    put(8'h44, 8'hC0);                       put(8'h45, 8'h60);
    put(8'h46, 8'hB0);                       put(8'h47, 8'h50);
    put(8'h50, enc(4'h2, 1'b1, 1'b0, MDIR)); put(8'h51, 8'hB2);
    do_reset();
    wait_halt("R8");
    check("R5 R8 compare equal, jz taken, rd kept", mem[8'hB0], 8'h05);
    check("R8 jnz taken then jmp", mem[8'hB1], 8'h77);
    check("R12 load keeps zero flag", mem[8'hB2], 8'h09);
  endtask

  // R9: wrap with operand at 0x00, under back-pressure
  task automatic t_wrap();
    stall_en = 1'b1;
    clear_mem();
    put(8'h00, 8'h0C);
    put(8'h01, enc(4'h5, 1'b1, 1'b0, MIMM)); put(8'h02, 8'h00);
    put(8'h03, 8'hB0);                       put(8'h04, 8'hF0);
    put(8'h05, enc(4'h2, 1'b0, 1'b0, MDIR)); put(8'h06, 8'hC0);
    put(8'hF0, enc(4'h1, 1'b1, 1'b0, MIMM)); put(8'hF1, 8'h01);
    put(8'hF2, enc(4'h1, 1'b0, 1'b0, MIMM)); put(8'hF3, 8'h20);
    put(8'hF4, 8'hA0);                       put(8'hF5, 8'hFF);
    put(8'hFF, enc(4'h3, 1'b0, 1'b0, MIMM));
    do_reset();
    wait_halt("R9");
    check("R9 operand fetched after wrap", mem[8'hC0], 8'h2C);
    check("R11 stalled request held", hold_err[7:0], 8'h00);
    stall_en = 1'b0;
  endtask

  // R10: halt is sticky and silent
  task automatic t_halt();
    int reqs = 0;
    stall_en = 1'b0;
    clear_mem();
    do_reset();
    wait_halt("R10");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req_valid) reqs++;
    end
    check("R10 no requests after halt", reqs[7:0], 8'h00);
    check("R10 halted stays high", {7'd0, halted}, 8'h01);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_arith();
    t_modes(1'b0, "plain");
    t_unary();
    t_branch();
    t_wrap();
    t_modes(1'b1, "stalled");
    check("R11 stalled request held", hold_err[7:0], 8'h00);
    t_halt();
    done = 1'b1;
    final_report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      final_report();
    end
  end

endmodule